// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a synchronous static RAM that can switch between reads and writes on any clock with no idle cycle between them. The data word is 36 bits wide, split into four 9-bit byte lanes. The array depth comes from an address-width parameter and is kept small so the model stays cheap in simulation. On every clock edge where the clock enable is active, the model decodes one of three commands: a load that starts a new read or write, an advance that continues the current burst, or a deselect.

Write data travels on the bus with the same latency as read data, so a controller can pack read and write commands back to back. A 2-bit burst counter steps through a 4-word block, in either linear or interleaved order. Writes are masked per byte lane. The output drive is gated at once by an output-enable pin that is not tied to the clock. A static mode pin picks the read latency: a pipelined two-stage path or a flow-through one-stage path.

Top module: `zbt_sram`

## Requirements
- R1: While `rst` is high and after it is released, `dq_oe` is 0 until a read completes.
- R2: On an edge where `cen_n` is 1, no internal state changes. Pending operations wait, and `dq_oe` and `dq_out` keep their values.
- R3: With `pipe_mode` = 1, a read load sampled at enabled edge E drives the addressed word on `dq_out` with `dq_oe` = 1 after enabled edge E+2.
- R4: With `pipe_mode` = 0, a read load sampled at enabled edge E drives its word after enabled edge E+1.
- R5: A write sampled at enabled edge E takes its data from `dq_in` at enabled edge E+2 (`pipe_mode` = 1) or E+1 (`pipe_mode` = 0). The bus is not driven for that slot. Reads and writes may be issued on consecutive edges in any mix.
- R6: Lane i is bits [9i+8:9i]. During a write, a lane is stored only when `bwe_n[i]` = 0, and the other lanes keep their old contents. The mask is sampled with the load and again with each burst beat.
- R7: With `burst_xor` = 0, beat n of a burst addresses low bits (start + n) mod 4. The upper address bits stay fixed.
- R8: With `burst_xor` = 1, beat n addresses low bits start XOR n.
- R9: `oe_n` = 1 forces `dq_oe` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the held read word.
- R10: A load (`adv_ld` = 0) with `sel0_n` = 1, `sel1` = 0 or `sel2_n` = 1 deselects the device. No read or write takes place, the bus floats for that slot, and later advances do nothing until a valid load.
- R11: A load starts a read when `rd_wr_n` = 1 and a write when it is 0. On an advance (`adv_ld` = 1), `rd_wr_n` is ignored and the burst keeps the type set by its load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high masks the edge |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| rd_wr_n | input | 1 | On a load: 1 = read, 0 = write |
| addr | input | ADDR_W | Word address, sampled on a load |
| bwe_n | input | 4 | Per-lane write enables, active low |
| dq_in | input | 36 | Write data bus |
| oe_n | input | 1 | Output enable, active low, not clocked |
| burst_xor | input | 1 | Static burst order: 1 = interleaved, 0 = linear |
| pipe_mode | input | 1 | Static read timing: 1 = pipelined, 0 = flow-through |
| dq_out | output | 36 | Read data, zero when not driven |
| dq_oe | output | 1 | High when the model drives the data bus |

## Verification
The main function is tried in both latency modes with three kinds of input pattern.

- Pure write bursts followed at once by read bursts that start at a different offset. These tell linear order apart from interleaved order.
- Alternating single reads and writes to the same address with no gaps. These show whether write data is caught in the correct slot and whether a read sees the write just before it.
- Burst beats with different lane masks. These show whether the mask is taken per beat or only from the load.

Further runs cover three more cases. Masked-clock gaps inside a burst show that the pipeline stalls instead of dropping data. Deselecting loads on each select in turn check R10. A write issued while deselected, with the same address read back afterwards, shows that a deselect does not disturb the array.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BEAT_W = 2;

    // One array operation travelling down the read/write pipeline
    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [LANES-1:0] lane_we;   // active-high lane write strobes
    } op_t;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,   // advance with no burst open
        CMD_LOAD  = 2'd1,   // load with all selects active
        CMD_DESEL = 2'd2,   // load with a select inactive
        CMD_ADV   = 2'd3    // advance inside an open burst
    } cmd_t;

    // Low address bits for a given beat of a 4-word burst
    function automatic logic [BEAT_W-1:0] burst_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/zsr_cmd_decode.sv
module zsr_cmd_decode
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sel_ok,
    input  logic              adv_ld,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bwe_n,
    input  logic              burst_xor,
    output op_t               s1_op,
    output logic [ADDR_W-1:0] s1_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_t              cmd;
    logic              active_q;
    logic              wr_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nx;
    logic [HI_W-1:0]   base_hi;

    assign beat_nx = beat_q + BEAT_W'(1);
    assign base_hi = base_q[ADDR_W-1:BEAT_W];

    always_comb begin
        if (!adv_ld) begin
            cmd = sel_ok ? CMD_LOAD : CMD_DESEL;
        end else begin
            cmd = active_q ? CMD_ADV : CMD_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            base_q   <= '0;
            beat_q   <= '0;
            s1_op    <= '0;
            s1_addr  <= '0;
        end else if (en) begin
            unique case (cmd)
                CMD_LOAD: begin
                    active_q      <= 1'b1;
                    wr_q          <= ~rd_wr_n;
                    base_q        <= addr;
                    beat_q        <= '0;
                    s1_op.valid   <= 1'b1;
                    s1_op.wr      <= ~rd_wr_n;
                    s1_op.lane_we <= rd_wr_n ? '0 : ~bwe_n;
                    s1_addr       <= addr;
                end
                CMD_ADV: begin
                    beat_q        <= beat_nx;
                    s1_op.valid   <= 1'b1;
                    s1_op.wr      <= wr_q;
                    s1_op.lane_we <= wr_q ? ~bwe_n : '0;
                    s1_addr       <= {base_hi, burst_offset(base_q[BEAT_W-1:0], beat_nx, burst_xor)};
                end
                CMD_DESEL: begin
                    active_q <= 1'b0;
                    s1_op    <= '0;
                end
                default: begin
                    s1_op <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/zsr_pipe.sv
module zsr_pipe
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              pipe_mode,
    input  op_t               s1_op,
    input  logic [ADDR_W-1:0] s1_addr,
    output op_t               act_op,
    output logic [ADDR_W-1:0] act_addr
);

    op_t               s2_op;
    logic [ADDR_W-1:0] s2_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= '0;
            s2_addr <= '0;
        end else if (en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
        end
    end

    // Flow-through executes from the first stage, pipelined from the second
    always_comb begin
        if (pipe_mode) begin
            act_op   = s2_op;
            act_addr = s2_addr;
        end else begin
            act_op   = s1_op;
            act_addr = s1_addr;
        end
    end

endmodule

// File: rtl/zsr_array.sv
module zsr_array
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  op_t               act_op,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dout_q,
    output logic              drv_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic do_wr;
    logic do_rd;

    assign do_wr = en & act_op.valid & act_op.wr;
    assign do_rd = en & act_op.valid & ~act_op.wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (do_wr && act_op.lane_we[g]) begin
                cells[act_addr] <= dq_in[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (do_rd) begin
                lane_q <= cells[act_addr];
            end
        end

        assign dout_q[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= 1'b0;
        end else if (en) begin
            drv_q <= do_rd;
        end
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              adv_ld,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bwe_n,
    input  logic [WORD_W-1:0] dq_in,
    input  logic              oe_n,
    input  logic              burst_xor,
    input  logic              pipe_mode,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              en;
    logic              sel_ok;
    op_t               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    op_t               act_op;
    logic [ADDR_W-1:0] act_addr;
    logic [WORD_W-1:0] dout_q;
    logic              drv_q;

    assign en     = ~cen_n;
    assign sel_ok = ~sel0_n & sel1 & ~sel2_n;

    zsr_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .sel_ok    (sel_ok),
        .adv_ld    (adv_ld),
        .rd_wr_n   (rd_wr_n),
        .addr      (addr),
        .bwe_n     (bwe_n),
        .burst_xor (burst_xor),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr)
    );

    zsr_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .pipe_mode (pipe_mode),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .act_op    (act_op),
        .act_addr  (act_addr)
    );

    zsr_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .act_op   (act_op),
        .act_addr (act_addr),
        .dq_in    (dq_in),
        .dout_q   (dout_q),
        .drv_q    (drv_q)
    );

    // Output gating does not wait for the clock
    assign dq_oe  = drv_q & ~oe_n;
    assign dq_out = dq_oe ? dout_q : '0;

endmodule

// File: rtl/zsr_checker.sv
module zsr_checker
    import zsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cen_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              adv_ld,
    input logic              rd_wr_n,
    input logic              pipe_mode,
    input logic              drv_q,
    input logic [WORD_W-1:0] dout_q
);

    logic good_load;
    logic rd_load;
    logic wr_load;
    logic bad_load;

    assign good_load = ~adv_ld & ~sel0_n & sel1 & ~sel2_n;
    assign rd_load   = good_load & rd_wr_n;
    assign wr_load   = good_load & ~rd_wr_n;
    assign bad_load  = ~adv_ld & ~(~sel0_n & sel1 & ~sel2_n);

    // R2: a masked edge changes neither the drive flag nor the held word
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(drv_q) && $stable(dout_q)));

    // R3: pipelined read drives after the second enabled edge
    a_r3_pipe_read: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !cen_n && $past(!cen_n) && $past(!rst, 2)
         && $past(!cen_n && rd_load, 2)) |=> drv_q);

    // R4: flow-through read drives after the next enabled edge
    a_r4_ft_read: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !cen_n && $past(!rst) && $past(!cen_n && rd_load)) |=> drv_q);

    // R5: the slot of a write leaves the bus floating
    a_r5_pipe_write_float: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !cen_n && $past(!cen_n) && $past(!rst, 2)
         && $past(!cen_n && wr_load, 2)) |=> !drv_q);

    a_r5_ft_write_float: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !cen_n && $past(!rst) && $past(!cen_n && wr_load)) |=> !drv_q);

    // R10: a deselecting load leaves the bus floating in its slot
    a_r10_desel_float: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !cen_n && $past(!rst) && $past(!cen_n && bad_load)) |=> !drv_q);

endmodule

bind zbt_sram zsr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cen_n     (cen_n),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .sel2_n    (sel2_n),
    .adv_ld    (adv_ld),
    .rd_wr_n   (rd_wr_n),
    .pipe_mode (pipe_mode),
    .drv_q     (drv_q),
    .dout_q    (dout_q)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
    import zsr_pkg::*;

    localparam int AW    = 6;
    localparam int WW    = WORD_W;
    localparam int DEPTH = 1 << AW;
    localparam logic [WW-1:0] JUNK = 36'hA5A5A5A5A;

    logic          clk = 1'b0;
    logic          rst;
    logic          cen_n, sel0_n, sel1, sel2_n, adv_ld, rd_wr_n;
    logic [AW-1:0] addr;
    logic [3:0]    bwe_n;
    logic [WW-1:0] dq_in;
    logic          oe_n, burst_xor, pipe_mode;
    logic [WW-1:0] dq_out;
    logic          dq_oe;

    always #5 clk = ~clk;

    zbt_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .addr(addr),
        .bwe_n(bwe_n), .dq_in(dq_in), .oe_n(oe_n), .burst_xor(burst_xor),
        .pipe_mode(pipe_mode), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        int            due;
        logic [WW-1:0] data;
        string         tag;
    } exp_t;

    int            checks = 0;
    int            fails  = 0;
    int            ecount = 0;
    logic [WW-1:0] rmem [DEPTH];
    logic [WW-1:0] wbus [int];
    exp_t          sb_q [$];

    // bench-side burst state
    bit            b_active = 0;
    bit            b_wr = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_beat = '0;

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic logic [WW-1:0] pat(input int k);
        return WW'(k) * 36'h02468ACE1 + 36'h13579BDF3;
    endfunction

    // Driver: sets one cycle of inputs and pushes expected reads to the scoreboard
    task automatic drive(input logic cen, input logic adv, input logic rw,
                         input logic s0n, input logic s1, input logic s2n,
                         input logic [AW-1:0] a, input logic [3:0] bw,
                         input logic [WW-1:0] wd, input string tag);
        int            e;
        int            lat;
        bit            opv;
        logic [AW-1:0] ea;
        @(negedge clk);
        cen_n = cen; adv_ld = adv; rd_wr_n = rw;
        sel0_n = s0n; sel1 = s1; sel2_n = s2n;
        addr = a; bwe_n = bw;
        dq_in = wbus.exists(ecount + 1) ? wbus[ecount + 1] : JUNK;
        if (!cen) begin
            e = ecount + 1;
            ecount = e;
            lat = pipe_mode ? 2 : 1;
            opv = 0;
            ea = '0;
            if (!adv) begin
                if (!s0n && s1 && !s2n) begin
                    b_active = 1; b_base = a; b_beat = 2'd0; b_wr = !rw;
                    ea = a; opv = 1;
                end else begin
                    b_active = 0;
                end
            end else if (b_active) begin
                b_beat = b_beat + 2'd1;
                ea = b_base;
                ea[1:0] = burst_xor ? (b_base[1:0] ^ b_beat) : 2'((b_base[1:0] + b_beat) % 4);
                opv = 1;
            end
            if (opv) begin
                if (b_wr) begin
                    wbus[e + lat] = wd;
                    for (int i = 0; i < 4; i++)
                        if (!bw[i]) rmem[ea][i*9 +: 9] = wd[i*9 +: 9];
                end else begin
                    sb_q.push_back('{e + lat, rmem[ea], tag});
                end
            end
        end
    endtask

    task automatic ld(input logic rw, input logic [AW-1:0] a, input logic [3:0] bw,
                      input logic [WW-1:0] wd, input string tag);
        drive(1'b0, 1'b0, rw, 1'b0, 1'b1, 1'b0, a, bw, wd, tag);
    endtask

    task automatic adv(input logic rw, input logic [3:0] bw, input logic [WW-1:0] wd, input string tag);
        drive(1'b0, 1'b1, rw, 1'b0, 1'b1, 1'b0, '0, bw, wd, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, 4'hF, JUNK, "R10");
    endtask

    task automatic hold();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 4'h0, JUNK, "R2");
    endtask

    // Monitor: pops expected reads in their due slot, otherwise expects a float or a hold
    int            m_e = 0;
    bit            m_drv = 0;
    logic [WW-1:0] m_data = '0;
    string         m_tag = "R1";

    always @(posedge clk) begin
        logic en_s;
        logic exp_oe;
        exp_t it;
        en_s = !cen_n && !rst;
        #2;
        if (rst) begin
            m_e = 0; m_drv = 0; m_tag = "R1";
        end else begin
            if (en_s) begin
                m_e++;
                if (sb_q.size() > 0 && sb_q[0].due == m_e) begin
                    it = sb_q.pop_front();
                    m_drv = 1; m_data = it.data; m_tag = it.tag;
                end else begin
                    m_drv = 0; m_tag = "R10";
                end
            end else if (!m_drv) begin
                m_tag = "R2";
            end
            exp_oe = m_drv && !oe_n;
            chk(dq_oe == exp_oe, m_tag, WW'(dq_oe), WW'(exp_oe));
            if (exp_oe) chk(dq_out == m_data, m_tag, dq_out, m_data);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) rmem[i] = '0;
        rst = 1'b1; cen_n = 1'b1; sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
        adv_ld = 1'b0; rd_wr_n = 1'b1; addr = '0; bwe_n = 4'hF; dq_in = JUNK;
        oe_n = 1'b0; burst_xor = 1'b0; pipe_mode = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(dq_oe == 1'b0, "R1", WW'(dq_oe), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R1", WW'(dq_oe), '0);

        // ---- pipelined, linear bursts (R3, R7, R11)
        ld(1'b0, 6'd8, 4'h0, pat(1), "R5");
        adv(1'b1, 4'h0, pat(2), "R11");
        adv(1'b1, 4'h0, pat(3), "R11");
        adv(1'b1, 4'h0, pat(4), "R11");
        ld(1'b1, 6'd10, 4'hF, JUNK, "R3");
        adv(1'b0, 4'h0, JUNK, "R7");
        adv(1'b0, 4'h0, JUNK, "R7");
        adv(1'b0, 4'h0, JUNK, "R11");
        // back-to-back mix (R5)
        ld(1'b0, 6'd30, 4'h0, pat(5), "R5");
        ld(1'b1, 6'd30, 4'hF, JUNK, "R5");
        ld(1'b0, 6'd31, 4'h0, pat(6), "R5");
        ld(1'b1, 6'd8, 4'hF, JUNK, "R5");
        ld(1'b1, 6'd31, 4'hF, JUNK, "R5");
        // lane masks (R6)
        ld(1'b0, 6'd5, 4'h0, pat(7), "R6");
        ld(1'b0, 6'd5, 4'b1010, pat(8), "R6");
        ld(1'b1, 6'd5, 4'hF, JUNK, "R6");
        ld(1'b0, 6'd12, 4'h0, pat(9), "R6");
        adv(1'b1, 4'h0, pat(10), "R6");
        adv(1'b1, 4'h0, pat(11), "R6");
        adv(1'b1, 4'h0, pat(12), "R6");
        ld(1'b0, 6'd12, 4'b1110, pat(13), "R6");
        adv(1'b1, 4'b0111, pat(14), "R6");
        ld(1'b1, 6'd12, 4'hF, JUNK, "R6");
        adv(1'b1, 4'hF, JUNK, "R6");
        idle(3);

        // ---- interleaved order (R8)
        burst_xor = 1'b1;
        ld(1'b0, 6'd17, 4'h0, pat(20), "R8");
        adv(1'b0, 4'h0, pat(21), "R8");
        adv(1'b0, 4'h0, pat(22), "R8");
        adv(1'b0, 4'h0, pat(23), "R8");
        ld(1'b1, 6'd18, 4'hF, JUNK, "R8");
        adv(1'b1, 4'hF, JUNK, "R8");
        adv(1'b1, 4'hF, JUNK, "R8");
        adv(1'b1, 4'hF, JUNK, "R8");

        // ---- clock masking inside a burst (R2)
        ld(1'b1, 6'd9, 4'hF, JUNK, "R2");
        hold();
        hold();
        adv(1'b1, 4'hF, JUNK, "R2");
        hold();
        idle(3);

        // ---- asynchronous output enable (R9)
        ld(1'b1, 6'd16, 4'hF, JUNK, "R9");
        idle(2);
        hold();
        #1;
        chk(dq_oe == 1'b1 && dq_out == rmem[16], "R9", dq_out, rmem[16]);
        oe_n = 1'b1;
        #1;
        chk(dq_oe == 1'b0, "R9", WW'(dq_oe), '0);
        oe_n = 1'b0;
        #1;
        chk(dq_oe == 1'b1 && dq_out == rmem[16], "R9", dq_out, rmem[16]);
        idle(3);

        // ---- deselect on each select (R10)
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd8, 4'hF, JUNK, "R10");
        adv(1'b1, 4'hF, JUNK, "R10");
        adv(1'b1, 4'hF, JUNK, "R10");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd8, 4'hF, JUNK, "R10");
        adv(1'b1, 4'hF, JUNK, "R10");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd8, 4'h0, pat(40), "R10");
        adv(1'b0, 4'h0, pat(41), "R10");
        ld(1'b1, 6'd8, 4'hF, JUNK, "R10");
        ld(1'b1, 6'd9, 4'hF, JUNK, "R10");
        idle(3);

        // ---- flow-through timing (R4, R5, R7, R8)
        pipe_mode = 1'b0;
        burst_xor = 1'b0;
        idle(2);
        ld(1'b0, 6'd40, 4'h0, pat(50), "R5");
        adv(1'b1, 4'h0, pat(51), "R5");
        adv(1'b1, 4'h0, pat(52), "R5");
        adv(1'b1, 4'h0, pat(53), "R5");
        ld(1'b1, 6'd41, 4'hF, JUNK, "R4");
        adv(1'b0, 4'hF, JUNK, "R7");
        adv(1'b0, 4'hF, JUNK, "R7");
        adv(1'b0, 4'hF, JUNK, "R7");
        ld(1'b0, 6'd50, 4'h0, pat(54), "R5");
        ld(1'b1, 6'd50, 4'hF, JUNK, "R4");
        ld(1'b0, 6'd50, 4'b0101, pat(55), "R6");
        ld(1'b1, 6'd50, 4'hF, JUNK, "R6");
        ld(1'b1, 6'd40, 4'hF, JUNK, "R4");
        hold();
        ld(1'b1, 6'd43, 4'hF, JUNK, "R2");
        idle(2);
        burst_xor = 1'b1;
        idle(1);
        ld(1'b1, 6'd42, 4'hF, JUNK, "R8");
        adv(1'b1, 4'hF, JUNK, "R8");
        adv(1'b1, 4'hF, JUNK, "R8");
        adv(1'b1, 4'hF, JUNK, "R8");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd40, 4'hF, JUNK, "R10");
        adv(1'b1, 4'hF, JUNK, "R10");
        idle(4);

        while (sb_q.size() > 0) idle(1);
        idle(2);
        summary();
        $finish;
    end

endmodule